// File: doc/BRIEF.md
# Serial Audio Frame Transmitter

This block takes 32-bit words from a sample FIFO and sends them, MSB first, on a single serial data line. It does not generate any clocks. A separate clock generator provides a bit-clock enable (`bclk_en_i`), which is high for one system clock at each falling edge of the bit clock. It also provides the frame clock (`lrck_i`). The serial output changes only on those ticks.

A set of static control fields chooses the framing:

- **Frame standard:** the I2S family or PCM/DSP framing.
- **Justification inside a slot:** standard I2S, left-justified or right-justified.
- **PCM sync delay:** 0 to 3 bit clocks.
- **Valid data width.**
- **Slot count per frame:** 2, 4, 6 or 8.

Each slot is 32 bit clocks long. One FIFO word is consumed per active slot, at the tick that carries the first bit of that slot. The FIFO is first-word-fall-through: `fifo_rdata_i` must already hold the head word, and `fifo_pop_o` consumes it in the same cycle.

A transfer-enable bit gates the whole serializer. While it is low, the line stays low, no words are read, and frame alignment is dropped. After it rises, nothing is sent until the next frame start edge.

Top module: `audio_frame_tx`

## Requirements
- R1: After reset, `sdo_o` is low. In any cycle where `xfer_en_i` is low, `fifo_pop_o` is low, and `sdo_o` is low from the next clock on.
- R2: `lrck_i` is sampled only on ticks (`bclk_en_i` high), against the level taken at the previous tick; that level is low after reset. A frame starts at a tick where `lrck_i` has fallen (I2S family, `std_pcm_i`=0) or risen (PCM, `std_pcm_i`=1). `sdo_o` changes only in the clock after a tick, so gaps between ticks do not alter the bit sequence.
- R3: With `std_pcm_i`=0 and `just_mode_i`=0 (standard I2S), the MSB of slot 0 is on the line at tick 1 after the start tick; the start tick is tick 0.
- R4: With `std_pcm_i`=0 and `just_mode_i`=1 (left-justified), the MSB is sent at the start tick itself. Code 3 behaves the same as code 1.
- R5: With `std_pcm_i`=0 and `just_mode_i`=2 (right-justified), slot k spans ticks 32k to 32k+31. Its word's LSB lands at tick 32k+31, and the bits before the valid field are low.
- R6: With `std_pcm_i`=1, the MSB of slot 0 is sent at tick `sync_dly_i` (0..3) after the sync tick. Data is MSB-first and `just_mode_i` is ignored.
- R7: `width_code_i` holds the valid width minus one (15 means 16 bits). Only bits [W-1:0] of the word are sent. The other positions of the slot are low.
- R8: `chan_sel_i` codes 0/1/2/3 select 2/4/6/8 slots. Slots past that count send low and consume no word, including those in a frame longer than the slot count.
- R9: `fifo_pop_o` is high in exactly the cycle of the tick that carries bit 0 of an active slot. The word presented on `fifo_rdata_i` in that cycle is the one serialized.
- R10: After `xfer_en_i` rises, no word is consumed and `sdo_o` stays low until the first frame start edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bclk_en_i | input | 1 | Tick: one cycle per bit-clock falling edge |
| lrck_i | input | 1 | Frame clock / PCM sync level |
| std_pcm_i | input | 1 | 0 I2S family, 1 PCM framing |
| just_mode_i | input | 2 | 0 I2S, 1 left, 2 right, 3 as left |
| sync_dly_i | input | 2 | PCM delay in bit clocks, 0..3 |
| width_code_i | input | 5 | Valid data width minus one |
| chan_sel_i | input | 2 | Slot count code, 2/4/6/8 |
| xfer_en_i | input | 1 | Transfer enable |
| fifo_rdata_i | input | 32 | Head word of the sample FIFO |
| sdo_o | output | 1 | Serial data |
| fifo_pop_o | output | 1 | Consume the head word |

## Verification
The frame start edge and a slot load can fall on the same tick. This happens in left-justified mode and in PCM mode with zero delay. In those cases the word must be popped, and its MSB must reach the line, on the same tick that resets the frame position.

A second collision is a drop of `xfer_en_i` in a cycle that would have popped. The bench covers it by disabling transfer in the middle of a frame and re-enabling it in the middle of another.

Every cycle is judged against a behavioural model. The model holds a bit queue per slot and a word index, and it predicts both the pop strobe and the line level.

// File: rtl/aftx_pkg.sv
package aftx_pkg;
  localparam int unsigned SLOT_W  = 32;
  localparam int unsigned WCODE_W = $clog2(SLOT_W);
  localparam int unsigned POS_W   = 10;

  typedef enum logic [1:0] {
    JUST_I2S   = 2'd0,
    JUST_LEFT  = 2'd1,
    JUST_RIGHT = 2'd2,
    JUST_ALT   = 2'd3
  } just_e;
endpackage

// File: rtl/aftx_frame_track.sv
module aftx_frame_track #(
  parameter int unsigned POS_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             lrck_i,
  input  logic             pcm_i,
  output logic             start_o,
  output logic [POS_W-1:0] pos_o
);
  localparam logic [POS_W-1:0] POS_MAX = {POS_W{1'b1}};

  logic             lr_q;
  logic [POS_W-1:0] cnt_q;

  assign start_o = tick_i & (pcm_i ? (lrck_i & ~lr_q) : (~lrck_i & lr_q));
  assign pos_o   = start_o ? '0 : ((cnt_q == POS_MAX) ? POS_MAX : cnt_q + 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lr_q  <= 1'b0;
      cnt_q <= '0;
    end else if (tick_i) begin
      lr_q  <= lrck_i;
      cnt_q <= pos_o;
    end
  end
endmodule

// File: rtl/aftx_slot_sched.sv
module aftx_slot_sched
  import aftx_pkg::*;
#(
  parameter int unsigned POS_W  = 10,
  parameter int unsigned SLOT_W = 32
) (
  input  logic [POS_W-1:0] pos_i,
  input  logic             pcm_i,
  input  logic [1:0]       just_i,
  input  logic [1:0]       dly_i,
  input  logic [1:0]       chan_sel_i,
  output logic             slot_start_o,
  output logic             slot_live_o,
  output logic             right_just_o
);
  localparam int unsigned SLOT_LG = $clog2(SLOT_W);
  localparam int unsigned IDX_W   = POS_W - SLOT_LG;

  logic [1:0]       off;
  logic [POS_W-1:0] rel;
  logic             in_range;
  logic [IDX_W-1:0] idx;
  logic [IDX_W-1:0] n_slots;

  always_comb begin
    if (pcm_i)                       off = dly_i;
    else if (just_i == 2'(JUST_I2S)) off = 2'd1;
    else                             off = 2'd0;
  end

  assign in_range     = pos_i >= POS_W'(off);
  assign rel          = pos_i - POS_W'(off);
  assign idx          = rel[POS_W-1:SLOT_LG];
  assign n_slots      = IDX_W'({chan_sel_i, 1'b0}) + IDX_W'(2);
  assign slot_start_o = in_range && (rel[SLOT_LG-1:0] == '0);
  assign slot_live_o  = idx < n_slots;
  assign right_just_o = ~pcm_i && (just_i == 2'(JUST_RIGHT));
endmodule

// File: rtl/aftx_word_align.sv
module aftx_word_align #(
  parameter int unsigned SLOT_W  = 32,
  parameter int unsigned WCODE_W = 5
) (
  input  logic [SLOT_W-1:0]  word_i,
  input  logic [WCODE_W-1:0] wcode_i,
  input  logic               right_i,
  output logic [SLOT_W-1:0]  aligned_o
);
  logic [SLOT_W-1:0]  kept;
  logic [WCODE_W-1:0] lshift;

  for (genvar i = 0; i < SLOT_W; i++) begin : g_keep
    assign kept[i] = (WCODE_W'(i) <= wcode_i) ? word_i[i] : 1'b0;
  end

  assign lshift    = WCODE_W'(SLOT_W - 1) - wcode_i;
  assign aligned_o = right_i ? kept : (kept << lshift);
endmodule

// File: rtl/aftx_shifter.sv
module aftx_shifter #(
  parameter int unsigned SLOT_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              tick_i,
  input  logic              load_i,
  input  logic [SLOT_W-1:0] data_i,
  output logic              sdo_o
);
  logic [SLOT_W-1:0] shreg_q;
  logic              sdo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg_q <= '0;
      sdo_q   <= 1'b0;
    end else if (!run_i) begin
      shreg_q <= '0;
      sdo_q   <= 1'b0;
    end else if (tick_i) begin
      if (load_i) begin
        sdo_q   <= data_i[SLOT_W-1];
        shreg_q <= data_i << 1;
      end else begin
        sdo_q   <= shreg_q[SLOT_W-1];
        shreg_q <= shreg_q << 1;
      end
    end
  end

  assign sdo_o = sdo_q;
endmodule

// File: rtl/audio_frame_tx.sv
module audio_frame_tx
  import aftx_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                bclk_en_i,
  input  logic                lrck_i,
  input  logic                std_pcm_i,
  input  logic [1:0]          just_mode_i,
  input  logic [1:0]          sync_dly_i,
  input  logic [WCODE_W-1:0]  width_code_i,
  input  logic [1:0]          chan_sel_i,
  input  logic                xfer_en_i,
  input  logic [SLOT_W-1:0]   fifo_rdata_i,
  output logic                sdo_o,
  output logic                fifo_pop_o
);
  logic             start;
  logic [POS_W-1:0] pos;
  logic             slot_start, slot_live, right_just;
  logic             synced_q, synced_now, load;
  logic [SLOT_W-1:0] aligned, load_data;

  aftx_frame_track #(.POS_W(POS_W)) i_track (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (bclk_en_i),
    .lrck_i (lrck_i),
    .pcm_i  (std_pcm_i),
    .start_o(start),
    .pos_o  (pos)
  );

  aftx_slot_sched #(.POS_W(POS_W), .SLOT_W(SLOT_W)) i_sched (
    .pos_i       (pos),
    .pcm_i       (std_pcm_i),
    .just_i      (just_mode_i),
    .dly_i       (sync_dly_i),
    .chan_sel_i  (chan_sel_i),
    .slot_start_o(slot_start),
    .slot_live_o (slot_live),
    .right_just_o(right_just)
  );

  aftx_word_align #(.SLOT_W(SLOT_W), .WCODE_W(WCODE_W)) i_align (
    .word_i   (fifo_rdata_i),
    .wcode_i  (width_code_i),
    .right_i  (right_just),
    .aligned_o(aligned)
  );

  // alignment only after a start edge seen while enabled
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        synced_q <= 1'b0;
    else if (!xfer_en_i) synced_q <= 1'b0;
    else if (start)      synced_q <= 1'b1;
  end

  assign synced_now = synced_q | start;
  assign load       = synced_now & slot_start;
  assign load_data  = slot_live ? aligned : '0;
  assign fifo_pop_o = xfer_en_i & bclk_en_i & load & slot_live;

  aftx_shifter #(.SLOT_W(SLOT_W)) i_shift (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (xfer_en_i),
    .tick_i(bclk_en_i),
    .load_i(load),
    .data_i(load_data),
    .sdo_o (sdo_o)
  );
endmodule

// File: rtl/aftx_tx_checker.sv
module aftx_tx_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic bclk_en_i,
  input logic xfer_en_i,
  input logic sdo_o,
  input logic fifo_pop_o
);
  assert_no_pop_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !xfer_en_i |-> !fifo_pop_o);

  assert_line_low_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !xfer_en_i |=> !sdo_o);

  assert_pop_on_tick_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_pop_o |-> bclk_en_i);

  assert_hold_between_ticks_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bclk_en_i && xfer_en_i) |=> $stable(sdo_o));
endmodule

bind audio_frame_tx aftx_tx_checker i_aftx_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .bclk_en_i (bclk_en_i),
  .xfer_en_i (xfer_en_i),
  .sdo_o     (sdo_o),
  .fifo_pop_o(fifo_pop_o)
);

// File: tb/test_audio_frame_tx.sv
`timescale 1ns/1ps
module test_audio_frame_tx;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        bclk_en_i = 1'b0;
  logic        lrck_i = 1'b0;
  logic        std_pcm_i = 1'b0;
  logic [1:0]  just_mode_i = 2'd0;
  logic [1:0]  sync_dly_i = 2'd0;
  logic [4:0]  width_code_i = 5'd15;
  logic [1:0]  chan_sel_i = 2'd0;
  logic        xfer_en_i = 1'b0;
  logic [31:0] fifo_rdata_i = '0;
  logic        sdo_o, fifo_pop_o;

  int checks = 0;
  int errors = 0;
  string phase = "R1";
  bit done = 0;

  int m_pos = 0;
  bit m_lr = 0;
  bit m_synced = 0;
  bit m_sdo = 0;
  int rd_idx = 0;
  bit bitq[$];

  always #2.5 clk_i = ~clk_i;

  audio_frame_tx i_audio_frame_tx (.*);

  function automatic logic [31:0] word_at(int i);
    return (32'h9E3779B9 * 32'(i + 1)) ^ (32'(i) << 7) ^ 32'h00A5_5A00;
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  // one system clock; called at a negedge
  task automatic step(bit en, bit lr);
    bit start, exp_pop, nsdo;
    int off, w, nch, slot;
    logic [31:0] wd;
    bclk_en_i = en;
    lrck_i = lr;
    fifo_rdata_i = word_at(rd_idx);
    #0.5;
    exp_pop = 0;
    nsdo = m_sdo;
    start = 0;
    if (en) begin
      start = std_pcm_i ? (lr && !m_lr) : (!lr && m_lr);
      m_pos = start ? 0 : ((m_pos >= 1023) ? 1023 : m_pos + 1);
      m_lr = lr;
    end
    if (!xfer_en_i) begin
      m_synced = 0;
      bitq.delete();
      nsdo = 0;
    end else if (en) begin
      if (start) m_synced = 1;
      off = std_pcm_i ? int'(sync_dly_i) : ((just_mode_i == 2'd0) ? 1 : 0);
      w = int'(width_code_i) + 1;
      nch = 2 * (int'(chan_sel_i) + 1);
      if (m_synced && m_pos >= off && ((m_pos - off) % 32) == 0) begin
        slot = (m_pos - off) / 32;
        bitq.delete();
        if (slot < nch) begin
          exp_pop = 1;
          wd = word_at(rd_idx);
          for (int b = 0; b < 32; b++) begin
            if (!std_pcm_i && just_mode_i == 2'd2)
              bitq.push_back((b >= 32 - w) ? wd[31 - b] : 1'b0);
            else
              bitq.push_back((b < w) ? wd[w - 1 - b] : 1'b0);
          end
        end
      end
      nsdo = (bitq.size() > 0) ? bitq.pop_front() : 1'b0;
    end
    chk(fifo_pop_o == exp_pop, "R9", {"pop in phase ", phase}, int'(fifo_pop_o), int'(exp_pop));
    @(posedge clk_i);
    if (exp_pop) rd_idx++;
    m_sdo = nsdo;
    @(negedge clk_i);
    chk(sdo_o == m_sdo, phase, "sdo", int'(sdo_o), int'(m_sdo));
  endtask

  task automatic run_frames(int n, int len, int gap);
    bit lr;
    for (int f = 0; f < n; f++) begin
      for (int t = 0; t < len; t++) begin
        lr = std_pcm_i ? (t == 0) : (t >= len / 2);
        step(1, lr);
        for (int g = 0; g < ((gap < 0) ? (t % 3) : gap); g++) step(0, lr);
      end
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, lrck_i);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1: reset state
    chk(sdo_o == 1'b0, "R1", "sdo in reset", int'(sdo_o), 0);
    chk(fifo_pop_o == 1'b0, "R1", "pop in reset", int'(fifo_pop_o), 0);
    rst_ni = 1'b1;
    lrck_i = 1'b1;
    idle(4);
    // R1: disabled, ticks and edges running
    phase = "R1";
    xfer_en_i = 0;
    run_frames(2, 64, 0);

    // R3 + R7: standard I2S, 16-bit
    phase = "R3 R7";
    std_pcm_i = 0; just_mode_i = 2'd0; width_code_i = 5'd15; chan_sel_i = 2'd0;
    xfer_en_i = 1;
    run_frames(3, 64, 0);

    // R4: left-justified, 24-bit
    phase = "R4";
    just_mode_i = 2'd1; width_code_i = 5'd23;
    run_frames(3, 64, 0);
    // R4: code 3 acts as left
    just_mode_i = 2'd3; width_code_i = 5'd31;
    run_frames(2, 64, 0);

    // R5: right-justified, 16 and 20 bits
    phase = "R5";
    just_mode_i = 2'd2; width_code_i = 5'd15;
    run_frames(2, 64, 0);
    width_code_i = 5'd19;
    run_frames(2, 64, 0);

    // R6: PCM with each delay, justification field set to right to show it is ignored
    phase = "R6";
    std_pcm_i = 1; just_mode_i = 2'd2; width_code_i = 5'd31;
    for (int d = 0; d < 4; d++) begin
      sync_dly_i = 2'(d);
      run_frames(2, 64, 0);
    end

    // R8: eight slots, then frames longer than the slot count
    phase = "R8";
    std_pcm_i = 0; just_mode_i = 2'd1; width_code_i = 5'd15;
    chan_sel_i = 2'd3;
    run_frames(2, 256, 0);
    chan_sel_i = 2'd1;
    run_frames(2, 128, 0);
    chan_sel_i = 2'd0;
    run_frames(2, 128, 0);

    // R2: irregular gaps between ticks
    phase = "R2";
    just_mode_i = 2'd0; width_code_i = 5'd23;
    run_frames(2, 64, -1);
    std_pcm_i = 1; sync_dly_i = 2'd1;
    run_frames(2, 64, 2);

    // R1 + R10: drop enable mid-frame, re-enable mid-frame
    std_pcm_i = 0; just_mode_i = 2'd0; width_code_i = 5'd15;
    run_frames(1, 64, 0);
    phase = "R1";
    for (int t = 0; t < 20; t++) step(1, 1'b0);
    xfer_en_i = 0;
    for (int t = 20; t < 64; t++) step(1, t >= 32);
    for (int t = 0; t < 40; t++) step(1, t >= 32);
    phase = "R10";
    xfer_en_i = 1;
    for (int t = 40; t < 64; t++) step(1, t >= 32);
    run_frames(2, 64, 0);

    idle(4);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule